// File: doc/BRIEF.md
# External Memory Bus Controller

This block turns single requests from inside the chip into accesses on an external memory bus. A request carries a 24-bit byte address, 16 bits of write data, two byte enables and a read/write flag. The block runs the external cycle and returns a one-cycle acknowledge together with the read data. The external side can be set up in four ways. The address and data can share one set of 16 pad lanes (multiplexed) or use separate lanes (demultiplexed). In either case the data path can be 8 or 16 bits wide. The block produces an address latch pulse, a read strobe, and a write strobe. The write strobe follows one of two rules, chosen per access. Eight segment lines carry the upper address byte.

Each access runs through these phases: an address phase with the latch pulse, a data phase with the strobe, any wait cycles, and then one recovery cycle in which every strobe is low. Wait cycles are added while a ready input shows its inactive level, provided ready checking is enabled. Which level counts as active is configurable. The configuration inputs are captured when an access is accepted and do not change for the rest of that access. When a request needs both bytes but the data path is only 8 bits wide, the block runs two complete byte cycles, low byte first.

Top module: `ext_bus_ctrl`

## Requirements
- R1: In multiplexed mode, during the address phase (the cycle in which `bus_ale` is high), both pad lanes are driven (`bus_ad_oe` = 2'b11) and `bus_ad_out` carries bits 15:0 of the cycle address. In demultiplexed mode, no lane is driven in the address phase.
- R2: Lane drive during the data phase. In multiplexed 8-bit mode, the high lane (`bus_ad_oe[1]`) keeps driving address bits 15:8. Data uses the low lane only in 8-bit modes and both lanes in 16-bit modes. Write data is driven throughout the data phase. For reads, the data lanes are released. Every lane is released in the recovery cycle.
- R3: `bus_ale` is high for exactly one cycle at the start of each byte or word cycle.
- R4: `bus_rd` is high during the data phase of every read cycle and at no other time.
- R5: With `cfg_wrl`=0, `bus_wr` is high during the data phase of every write cycle. With `cfg_wrl`=1 on a 16-bit path, it is high only if `req_be[0]` is set. With `cfg_wrl`=1 on an 8-bit path, it is high on every write cycle.
- R6: Throughout an access, `bus_seg` shows bits 23:16 of the cycle address and `bus_addr` shows bits 15:0.
- R7: When `cfg_rdy_en`=1, the data phase is extended by one cycle for every clock edge at which `bus_ready` differs from `cfg_rdy_pol`. When `cfg_rdy_en`=0, `bus_ready` has no effect.
- R8: Each byte or word cycle lasts address + data (+ waits) + one recovery cycle. `req_ack` is a one-cycle pulse in the recovery cycle of the last cycle, and a new request can be accepted on the next edge.
- R9: On an 8-bit path, the byte enables select the cycles. `req_be`=2'b11 gives two cycles: the low byte at address bit 0 = 0, then the high byte at address bit 0 = 1. 2'b10 gives one high-byte cycle at address bit 0 = 1, carried on the low lane. Any other value gives one low-byte cycle at address bit 0 = 0.
- R10: Read data is sampled on the last data-phase cycle. A 16-bit path fills all 16 bits. On an 8-bit path, the low lane fills bits 7:0 in a low-byte cycle and bits 15:8 in a high-byte cycle. Bytes that are not read return zero.
- R11: Any change to the configuration inputs after an access has been accepted has no effect on that access.
- R12: While reset is held, all strobes, the acknowledge and all lane enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mux | input | 1 | 1 = address and data share the pad lanes |
| cfg_wide | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| cfg_wrl | input | 1 | 1 = write strobe only for the low byte on a 16-bit path |
| cfg_rdy_en | input | 1 | 1 = ready input inserts wait cycles |
| cfg_rdy_pol | input | 1 | Level of `bus_ready` that means ready |
| req_valid | input | 1 | Request present; hold until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables; bit 0 = low byte |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with `req_ack` |
| bus_ad_out | output | 16 | Pad lane output values |
| bus_ad_oe | output | 2 | Lane drive enables; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| bus_ad_in | input | 16 | Pad lane input values |
| bus_addr | output | 16 | Separate address bus, bits 15:0 |
| bus_seg | output | 8 | Segment address, bits 23:16 |
| bus_ale | output | 1 | Address latch pulse, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_ready | input | 1 | External ready, level set by `cfg_rdy_pol` |

## Verification
All four mode combinations are run with reads and writes. Comparing them separates the lane that is shared with address from the lanes that carry data only, and shows whether the high lane holds its address in 8-bit multiplexed cycles. Byte-enable patterns 2'b11, 2'b10 and 2'b01 on the 8-bit path distinguish split cycles from single cycles and check the low-then-high order. On the 16-bit path with the low-byte write rule, the same patterns show when the write strobe is suppressed. Ready is tested with both polarities, with checking disabled while ready is held inactive, and with the configuration inputs scrambled in the middle of an access. Together these tests show whether wait cycles follow the captured settings rather than the live inputs.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_DATA  = 2'd2,
        PH_RECOV = 2'd3
    } ebc_phase_e;

    typedef enum logic [1:0] {
        BC_LOW  = 2'd0,
        BC_HIGH = 2'd1,
        BC_WORD = 2'd2
    } ebc_beat_e;

    typedef struct packed {
        logic mux;
        logic wide;
        logic wrl;
        logic rdy_en;
        logic rdy_pol;
    } ebc_cfg_t;

endpackage

// File: rtl/ebc_ready_eval.sv
module ebc_ready_eval
    import ebc_pkg::*;
(
    input  ebc_phase_e phase_i,
    input  logic       rdy_en_i,
    input  logic       rdy_pol_i,
    input  logic       bus_ready_i,
    output logic       done_o
);

    logic level_ok;

    always_comb begin
        level_ok = (bus_ready_i == rdy_pol_i);
        done_o   = (phase_i == PH_DATA) && (!rdy_en_i || level_ok);
    end

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ebc_cfg_t          cfg_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [1:0]        req_be_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] bus_din_i,
    output ebc_phase_e        phase_o,
    output ebc_beat_e         beat_o,
    output logic              write_o,
    output ebc_cfg_t          cfg_o,
    output logic [ADDR_W-1:0] cyc_addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              be_lo_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int LANE_W = DATA_W / 2;

    typedef struct packed {
        ebc_phase_e        ph;
        ebc_beat_e         beat;
        logic              pend_hi;
        logic              write;
        ebc_cfg_t          cfg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        be;
        logic [DATA_W-1:0] rdata;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid_i) begin
                    st_d.ph    = PH_ADDR;
                    st_d.cfg   = cfg_i;
                    st_d.write = req_write_i;
                    st_d.addr  = req_addr_i;
                    st_d.wdata = req_wdata_i;
                    st_d.be    = req_be_i;
                    st_d.rdata = '0;
                    if (cfg_i.wide) begin
                        st_d.beat    = BC_WORD;
                        st_d.pend_hi = 1'b0;
                    end else if (req_be_i == 2'b10) begin
                        st_d.beat    = BC_HIGH;
                        st_d.pend_hi = 1'b0;
                    end else begin
                        st_d.beat    = BC_LOW;
                        st_d.pend_hi = (req_be_i == 2'b11);
                    end
                end
            end
            PH_ADDR: st_d.ph = PH_DATA;
            PH_DATA: begin
                if (done_i) begin
                    st_d.ph = PH_RECOV;
                    if (!st_q.write) begin
                        unique case (st_q.beat)
                            BC_WORD: st_d.rdata = bus_din_i;
                            BC_HIGH: st_d.rdata[DATA_W-1:LANE_W] = bus_din_i[LANE_W-1:0];
                            default: st_d.rdata[LANE_W-1:0] = bus_din_i[LANE_W-1:0];
                        endcase
                    end
                end
            end
            PH_RECOV: begin
                if (st_q.pend_hi) begin
                    st_d.pend_hi = 1'b0;
                    st_d.beat    = BC_HIGH;
                    st_d.ph      = PH_ADDR;
                end else begin
                    st_d.ph = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, beat: BC_LOW, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        phase_o  = st_q.ph;
        beat_o   = st_q.beat;
        write_o  = st_q.write;
        cfg_o    = st_q.cfg;
        wdata_o  = st_q.wdata;
        be_lo_o  = st_q.be[0];
        rdata_o  = st_q.rdata;
        ack_o    = (st_q.ph == PH_RECOV) && !st_q.pend_hi;
        unique case (st_q.beat)
            BC_WORD: cyc_addr_o = st_q.addr;
            BC_HIGH: cyc_addr_o = {st_q.addr[ADDR_W-1:1], 1'b1};
            default: cyc_addr_o = {st_q.addr[ADDR_W-1:1], 1'b0};
        endcase
    end

endmodule

// File: rtl/ebc_lane_drv.sv
module ebc_lane_drv
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  ebc_phase_e              phase_i,
    input  ebc_beat_e               beat_i,
    input  logic                    write_i,
    input  logic                    mux_i,
    input  logic                    wide_i,
    input  logic                    wrl_i,
    input  logic                    be_lo_i,
    input  logic [ADDR_W-1:0]       cyc_addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       ad_out_o,
    output logic [1:0]              ad_oe_o,
    output logic [DATA_W-1:0]       addr_o,
    output logic [ADDR_W-DATA_W-1:0] seg_o,
    output logic                    ale_o,
    output logic                    rd_o,
    output logic                    wr_o
);

    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    logic in_addr, in_data;

    assign in_addr = (phase_i == PH_ADDR);
    assign in_data = (phase_i == PH_DATA);

    assign ale_o  = in_addr;
    assign rd_o   = in_data && !write_i;
    assign wr_o   = in_data && write_i && (!wrl_i || !wide_i || be_lo_i);
    assign addr_o = cyc_addr_i[DATA_W-1:0];
    assign seg_o  = cyc_addr_i[ADDR_W-1:DATA_W];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] a_sl, d_sl;
        logic carry_data, keep_addr, drive;

        assign a_sl = cyc_addr_i[i*LANE_W +: LANE_W];

        if (i == 0) begin : g_low
            assign carry_data = 1'b1;
            assign keep_addr  = 1'b0;
            assign d_sl = (!wide_i && beat_i == BC_HIGH) ? wdata_i[DATA_W-1 -: LANE_W]
                                                         : wdata_i[LANE_W-1:0];
        end else begin : g_high
            assign carry_data = wide_i;
            assign keep_addr  = mux_i && !wide_i;
            assign d_sl = wdata_i[i*LANE_W +: LANE_W];
        end

        assign drive = (in_addr && mux_i) ||
                       (in_data && (keep_addr || (carry_data && write_i)));
        assign ad_oe_o[i] = drive;
        assign ad_out_o[i*LANE_W +: LANE_W] =
            !drive                 ? '0   :
            (in_addr || keep_addr) ? a_sl : d_sl;
    end

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_mux,
    input  logic                     cfg_wide,
    input  logic                     cfg_wrl,
    input  logic                     cfg_rdy_en,
    input  logic                     cfg_rdy_pol,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [1:0]               req_be,
    output logic                     req_ack,
    output logic [DATA_W-1:0]        req_rdata,
    output logic [DATA_W-1:0]        bus_ad_out,
    output logic [1:0]               bus_ad_oe,
    input  logic [DATA_W-1:0]        bus_ad_in,
    output logic [DATA_W-1:0]        bus_addr,
    output logic [ADDR_W-DATA_W-1:0] bus_seg,
    output logic                     bus_ale,
    output logic                     bus_rd,
    output logic                     bus_wr,
    input  logic                     bus_ready
);

    ebc_cfg_t          cfg_in, cfg_w;
    ebc_phase_e        phase_w;
    ebc_beat_e         beat_w;
    logic              write_w, be_lo_w, done_w;
    logic [ADDR_W-1:0] cyc_addr_w;
    logic [DATA_W-1:0] wdata_w;

    assign cfg_in = '{mux: cfg_mux, wide: cfg_wide, wrl: cfg_wrl,
                      rdy_en: cfg_rdy_en, rdy_pol: cfg_rdy_pol};

    ebc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg_in),
        .req_valid_i(req_valid),
        .req_write_i(req_write),
        .req_addr_i (req_addr),
        .req_wdata_i(req_wdata),
        .req_be_i   (req_be),
        .done_i     (done_w),
        .bus_din_i  (bus_ad_in),
        .phase_o    (phase_w),
        .beat_o     (beat_w),
        .write_o    (write_w),
        .cfg_o      (cfg_w),
        .cyc_addr_o (cyc_addr_w),
        .wdata_o    (wdata_w),
        .be_lo_o    (be_lo_w),
        .ack_o      (req_ack),
        .rdata_o    (req_rdata)
    );

    ebc_ready_eval u_rdy (
        .phase_i    (phase_w),
        .rdy_en_i   (cfg_w.rdy_en),
        .rdy_pol_i  (cfg_w.rdy_pol),
        .bus_ready_i(bus_ready),
        .done_o     (done_w)
    );

    ebc_lane_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
        .phase_i   (phase_w),
        .beat_i    (beat_w),
        .write_i   (write_w),
        .mux_i     (cfg_w.mux),
        .wide_i    (cfg_w.wide),
        .wrl_i     (cfg_w.wrl),
        .be_lo_i   (be_lo_w),
        .cyc_addr_i(cyc_addr_w),
        .wdata_i   (wdata_w),
        .ad_out_o  (bus_ad_out),
        .ad_oe_o   (bus_ad_oe),
        .addr_o    (bus_addr),
        .seg_o     (bus_seg),
        .ale_o     (bus_ale),
        .rd_o      (bus_rd),
        .wr_o      (bus_wr)
    );

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker
    import ebc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ale,
    input logic       rd,
    input logic       wr,
    input logic [1:0] oe,
    input logic       ack,
    input logic       ready,
    input ebc_phase_e phase,
    input ebc_cfg_t   cfg_q
);

    a_r3_ale_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));

    a_r2_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> !oe[0]);

    a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && cfg_q.rdy_en && ready != cfg_q.rdy_pol) |=> phase == PH_DATA);

    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r8_recovery_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RECOV) |-> (!ale && !rd && !wr && oe == 2'b00));

    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(cfg_q));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!ale && !rd && !wr && !ack && oe == 2'b00));

endmodule

bind ext_bus_ctrl ebc_checker u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .ale  (bus_ale),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .oe   (bus_ad_oe),
    .ack  (req_ack),
    .ready(bus_ready),
    .phase(phase_w),
    .cfg_q(cfg_w)
);

// File: tb/ext_bus_ctrl_test.sv
`timescale 1ns/1ps
module ext_bus_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mux = 0, cfg_wide = 0, cfg_wrl = 0, cfg_rdy_en = 0, cfg_rdy_pol = 1;
    logic req_valid = 0, req_write = 0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ack;
    logic [15:0] req_rdata, bus_ad_out, bus_ad_in, bus_addr;
    logic [1:0]  bus_ad_oe;
    logic [7:0]  bus_seg;
    logic        bus_ale, bus_rd, bus_wr;
    logic        bus_ready = 1'b1;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ext_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_mux(cfg_mux), .cfg_wide(cfg_wide), .cfg_wrl(cfg_wrl),
        .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_pol(cfg_rdy_pol),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ack(req_ack), .req_rdata(req_rdata),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_addr(bus_addr), .bus_seg(bus_seg), .bus_ale(bus_ale),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready)
    );

    // external memory model: returned bytes depend on the presented address
    assign bus_ad_in = {bus_addr[7:0] ^ 8'h3C, bus_addr[7:0] ^ 8'hA5};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st = 0;      // 0 idle, 1 address, 2 data, 3 recovery
    int          m_q[$];        // pending byte cycles: 0 low, 1 high, 2 word
    int          m_cur = 0;
    logic        m_write = 0, m_mux = 0, m_wide = 0, m_wrl = 0, m_ren = 0, m_rpol = 0;
    logic [23:0] m_addr = '0;
    logic [15:0] m_wdata = '0, m_rdata = '0;
    logic [1:0]  m_be = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
            m_q.delete();
            m_rdata = '0;
        end else begin
            case (m_st)
                0: if (req_valid) begin
                    m_write = req_write; m_mux = cfg_mux; m_wide = cfg_wide;
                    m_wrl = cfg_wrl; m_ren = cfg_rdy_en; m_rpol = cfg_rdy_pol;
                    m_addr = req_addr; m_wdata = req_wdata; m_be = req_be;
                    m_rdata = '0;
                    m_q.delete();
                    if (cfg_wide) m_q.push_back(2);
                    else if (req_be == 2'b11) begin m_q.push_back(0); m_q.push_back(1); end
                    else if (req_be == 2'b10) m_q.push_back(1);
                    else m_q.push_back(0);
                    m_cur = m_q.pop_front();
                    m_st = 1;
                end
                1: m_st = 2;
                2: if (!m_ren || bus_ready == m_rpol) begin
                    if (!m_write) begin
                        if (m_cur == 2) m_rdata = bus_ad_in;
                        else if (m_cur == 1) m_rdata[15:8] = bus_ad_in[7:0];
                        else m_rdata[7:0] = bus_ad_in[7:0];
                    end
                    m_st = 3;
                end
                default: if (m_q.size() > 0) begin
                    m_cur = m_q.pop_front();
                    m_st = 1;
                end else m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R12 ale", bus_ale, 0);
            chk("R12 rd", bus_rd, 0);
            chk("R12 wr", bus_wr, 0);
            chk("R12 ack", req_ack, 0);
            chk("R12 oe", bus_ad_oe, 0);
        end else begin
            logic [23:0] ca;
            logic [1:0]  e_oe;
            logic [7:0]  e_lo, e_hi;
            ca = (m_cur == 2) ? m_addr : {m_addr[23:1], (m_cur == 1)};
            e_oe = 2'b00;
            if (m_st == 1) e_oe = m_mux ? 2'b11 : 2'b00;
            else if (m_st == 2) begin
                if (m_write) e_oe = (m_wide || m_mux) ? 2'b11 : 2'b01;
                else         e_oe = (m_mux && !m_wide) ? 2'b10 : 2'b00;
            end
            e_lo = (m_st == 1) ? ca[7:0] :
                   (m_wide || m_cur != 1) ? m_wdata[7:0] : m_wdata[15:8];
            e_hi = (m_st == 1 || !m_wide) ? ca[15:8] : m_wdata[15:8];
            chk("R3 ale", bus_ale, m_st == 1);
            chk("R4 R7 rd", bus_rd, m_st == 2 && !m_write);
            chk("R5 R7 wr", bus_wr, m_st == 2 && m_write && (!m_wrl || !m_wide || m_be[0]));
            chk("R2 R11 oe", bus_ad_oe, e_oe);
            if (e_oe[0] && bus_ad_oe[0]) chk("R1 R2 low lane", bus_ad_out[7:0], e_lo);
            if (e_oe[1] && bus_ad_oe[1]) chk("R1 R2 high lane", bus_ad_out[15:8], e_hi);
            chk("R8 ack", req_ack, m_st == 3 && m_q.size() == 0);
            if (m_st != 0) begin
                chk("R6 seg", bus_seg, ca[23:16]);
                chk("R6 R9 addr", bus_addr, ca[15:0]);
            end
            if (m_st == 3 && m_q.size() == 0 && !m_write)
                chk("R10 rdata", req_rdata, m_rdata);
        end
    end

    // ---------------- ready generator ----------------
    int  wait_req = 0;
    int  wait_cnt = 0;
    logic drv_pol = 1'b1;

    always @(negedge clk) begin
        if (bus_ale) wait_cnt = wait_req;
        else if (wait_cnt > 0) wait_cnt--;
        bus_ready = (wait_cnt > 0) ? !drv_pol : drv_pol;
    end

    // ---------------- stimulus ----------------
    task automatic run(input logic mux, input logic wide, input logic wrl,
                       input logic ren, input logic rpol, input logic wr,
                       input logic [23:0] a, input logic [15:0] d,
                       input logic [1:0] be, input int waits, input bit scramble);
        @(negedge clk);
        cfg_mux = mux; cfg_wide = wide; cfg_wrl = wrl;
        cfg_rdy_en = ren; cfg_rdy_pol = rpol; drv_pol = rpol;
        wait_req = waits;
        req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        req_valid = 1'b1;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (scramble && n == 0) begin
                // R11: settings change after acceptance must not matter
                cfg_mux = !mux; cfg_wide = !wide; cfg_wrl = !wrl;
                cfg_rdy_en = !ren; cfg_rdy_pol = !rpol;
            end
            if (req_ack) break;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // mode sweep: mux, wide, wrl, rdy_en, rdy_pol, write, addr, data, be, waits, scramble
        run(1, 1, 0, 0, 1, 1, 24'h12_3456, 16'hBEEF, 2'b11, 0, 0);  // R1 R2 mux16 write
        run(1, 1, 0, 0, 1, 0, 24'h12_3456, 16'h0000, 2'b11, 0, 0);  // R10 mux16 read
        run(1, 0, 0, 0, 1, 1, 24'hA5_7F10, 16'hC0DE, 2'b11, 0, 0);  // R9 mux8 split write
        run(1, 0, 0, 0, 1, 0, 24'hA5_7F10, 16'h0000, 2'b11, 0, 0);  // R9 R10 mux8 split read
        run(0, 1, 1, 0, 1, 1, 24'h03_2222, 16'h1234, 2'b10, 0, 0);  // R5 no low-byte strobe
        run(0, 1, 1, 0, 1, 1, 24'h03_2222, 16'h5678, 2'b01, 0, 0);  // R5 low-byte strobe
        run(0, 1, 0, 0, 1, 1, 24'h03_2224, 16'h9ABC, 2'b10, 0, 0);  // R5 plain strobe
        run(0, 0, 0, 0, 1, 0, 24'h7E_0100, 16'h0000, 2'b10, 0, 0);  // R9 demux8 high only
        run(0, 0, 1, 0, 1, 1, 24'h7E_0102, 16'h00AA, 2'b01, 0, 0);  // R5 demux8 wrl
        run(0, 0, 0, 0, 1, 1, 24'hFF_FFFE, 16'h55AA, 2'b11, 0, 0);  // R2 demux8 split write
        run(0, 1, 0, 0, 1, 0, 24'h44_8000, 16'h0000, 2'b11, 0, 0);  // R2 demux16 read
        run(1, 1, 0, 1, 1, 0, 24'h20_0010, 16'h0000, 2'b11, 4, 0);  // R7 active-high waits
        run(0, 1, 0, 1, 0, 1, 24'h20_0020, 16'h7777, 2'b11, 3, 0);  // R7 active-low waits
        run(1, 0, 0, 0, 1, 0, 24'h20_0030, 16'h0000, 2'b11, 5, 0);  // R7 ready ignored
        run(1, 0, 0, 1, 1, 0, 24'h31_0F00, 16'h0000, 2'b11, 2, 1);  // R11 scramble
        run(0, 1, 1, 0, 0, 1, 24'h31_0F02, 16'h4321, 2'b01, 0, 1);  // R11 scramble write
        repeat (5) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule